// File: doc/BRIEF.md
# Lightweight User-Level Interrupt Dispatcher

This per-core unit lets event packets from accelerators and from the accelerator allocator reach a user-thread handler without a trip through the operating system. A thread first writes a registration: for one event source it records the thread ID that owns the handler, the handler address and one argument word. Each incoming packet carries a source ID, an event kind and a payload. The unit looks the source up in its table. When the source is registered to the thread that is running and the queue has room, the packet is queued. Otherwise it is diverted at once to a conventional OS interrupt output.

Queued packets are ranked by event kind, and the oldest packet wins within a rank. The unit hands exactly one packet at a time to the core pipeline as a handler vector: handler address, argument, kind, source and payload. It holds that vector until the handler-return acknowledge arrives. A queued packet is issued only while its owning thread is the one running. Redirecting the pipeline is left to the core.

Top module: `uirq_dispatch`

## Requirements
- R1: After reset, `vec_valid` and `os_req` are 0 and the registration table is empty. A packet that arrives before any registration is routed to the OS output.
- R2: A packet whose source has no valid table entry raises `os_req` for one cycle after the clock edge that samples it. That cycle carries the packet's source, kind and payload, and the packet is not queued.
- R3: A packet whose source is registered to a thread other than `cur_tid` at arrival is routed to the OS output in the same way as in R2.
- R4: A packet whose source is registered to `cur_tid` raises `vec_valid` at the second clock edge after it is sampled, provided the unit is idle and the queue is empty. The vector shows the registered handler address and argument plus the packet's kind, source and payload.
- R5: While `vec_valid` is 1 and `hret` is 0, `vec_valid` stays 1 and every vector field stays unchanged. The edge that samples `hret` clears `vec_valid`, and the earliest next vector appears one edge later.
- R6: Among queued packets, kind 0 (translation miss) is issued first, then kind 1 (task complete). Kind 2 (reservation granted) and kind 3 (reservation refused) share the lowest rank.
- R7: Between queued packets of equal rank, the one that arrived first is issued first.
- R8: A registered, thread-matching packet that arrives while the queue holds DEPTH packets goes to the OS output (R2 timing) and is not lost.
- R9: A queued packet is issued only on an edge at which `cur_tid` equals the thread that registered its source. Until then it waits in the queue.
- R10: A registration write with `reg_keep` = 0 removes the entry, and later packets from that source go to the OS output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Registration write strobe |
| reg_keep | input | 1 | 1 installs the entry, 0 removes it |
| reg_src | input | SRC_W | Event source being registered |
| reg_tid | input | TID_W | Thread that owns the handler |
| reg_handler | input | ADDR_W | Handler entry address |
| reg_arg | input | ARG_W | Handler argument |
| pkt_valid | input | 1 | Incoming packet strobe |
| pkt_src | input | SRC_W | Packet source ID |
| pkt_kind | input | 2 | Event kind (0 miss, 1 done, 2 granted, 3 refused) |
| pkt_payload | input | PAY_W | Packet payload |
| cur_tid | input | TID_W | Thread currently running on the core |
| hret | input | 1 | Handler-return acknowledge |
| vec_valid | output | 1 | Handler vector presented |
| vec_handler | output | ADDR_W | Handler address |
| vec_arg | output | ARG_W | Handler argument |
| vec_kind | output | 2 | Event kind of the issued packet |
| vec_src | output | SRC_W | Source of the issued packet |
| vec_payload | output | PAY_W | Payload of the issued packet |
| os_req | output | 1 | One-cycle OS interrupt request |
| os_src | output | SRC_W | Source of the diverted packet |
| os_kind | output | 2 | Kind of the diverted packet |
| os_payload | output | PAY_W | Payload of the diverted packet |

## Verification
The bench fills the queue behind an active handler with mixed kinds, including two lowest-rank packets. It then checks the order in which they drain. A design that ranked refused replies apart from granted ones, or that broke ties by slot position rather than by age, would issue them in the wrong order. The bench also sends a fifth packet into the full queue, where a wrong design would drop or overwrite a packet instead of raising `os_req`. It switches the running thread just as a handler returns, which catches a design that issues a vector to the wrong thread. A test that unregisters a source catches a stale table entry that still routes packets to a handler.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  typedef enum logic [1:0] {
    EV_XLATE_MISS = 2'd0,
    EV_TASK_END   = 2'd1,
    EV_GRANT      = 2'd2,
    EV_REFUSE     = 2'd3
  } ev_kind_e;

  // Lower rank is served first; both allocator replies share one rank.
  function automatic logic [1:0] ev_rank(input logic [1:0] kind);
    return (kind == EV_REFUSE) ? 2'd2 : kind;
  endfunction

endpackage

// File: rtl/uirq_regtab.sv
module uirq_regtab #(
  parameter int SRC_W  = 3,
  parameter int TID_W  = 4,
  parameter int ADDR_W = 16,
  parameter int ARG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_keep,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ARG_W-1:0]  wr_arg,
  input  logic [SRC_W-1:0]  rd_src,
  output logic              rd_hit,
  output logic [TID_W-1:0]  rd_tid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ARG_W-1:0]  rd_arg
);
  localparam int ENTRIES = 1 << SRC_W;

  logic [ENTRIES-1:0] live_q;
  logic [TID_W-1:0]   tid_mem  [ENTRIES];
  logic [ADDR_W-1:0]  addr_mem [ENTRIES];
  logic [ARG_W-1:0]   arg_mem  [ENTRIES];

  // Payload columns carry no reset so they map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tid_mem[wr_src]  <= wr_tid;
      addr_mem[wr_src] <= wr_addr;
      arg_mem[wr_src]  <= wr_arg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        live_q         <= '0;
    else if (wr_en) live_q[wr_src] <= wr_keep;
  end

  assign rd_hit  = live_q[rd_src];
  assign rd_tid  = tid_mem[rd_src];
  assign rd_addr = addr_mem[rd_src];
  assign rd_arg  = arg_mem[rd_src];

  // R10
  unreg_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_keep) |=> !live_q[$past(wr_src)]);
endmodule

// File: rtl/uirq_queue.sv
module uirq_queue
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [1:0]        push_kind,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_i,
  output logic              full_o,
  output logic              sel_valid,
  output logic [1:0]        sel_kind,
  output logic [DATA_W-1:0] sel_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Slot 0 always holds the oldest packet; removal closes the gap.
  logic [1:0]        kind_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [1:0]        kind_n [DEPTH];
  logic [DATA_W-1:0] data_n [DEPTH];
  logic [CNT_W-1:0]  count_q, count_n;
  logic [IDX_W-1:0]  sel_idx;
  logic [1:0]        best_rank;

  always_comb begin
    best_rank = 2'd3;
    sel_idx   = '0;
    sel_valid = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < count_q && ev_rank(kind_q[i]) <= best_rank) begin
        best_rank = ev_rank(kind_q[i]);
        sel_idx   = IDX_W'(i);
        sel_valid = 1'b1;
      end
    end
  end

  assign sel_kind = kind_q[sel_idx];
  assign sel_data = data_q[sel_idx];
  assign full_o   = (count_q == CNT_W'(DEPTH));

  always_comb begin
    kind_n  = kind_q;
    data_n  = data_q;
    count_n = count_q;
    if (pop_i && sel_valid) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= sel_idx) begin
          kind_n[i] = kind_q[i+1];
          data_n[i] = data_q[i+1];
        end
      end
      count_n = count_q - 1'b1;
    end
    if (push_i && count_n < CNT_W'(DEPTH)) begin
      kind_n[IDX_W'(count_n)] = push_kind;
      data_n[IDX_W'(count_n)] = push_data;
      count_n = count_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    kind_q <= kind_n;
    data_q <= data_n;
    if (rst) count_q <= '0;
    else     count_q <= count_n;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);

  // R6
  always_ff @(posedge clk) begin
    if (!rst && sel_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) < count_q)
          prio_order_chk: assert (ev_rank(kind_q[i]) >= ev_rank(sel_kind))
            else $error("queued packet outranks the selected one");
      end
    end
  end
endmodule

// File: rtl/uirq_dispatch.sv
module uirq_dispatch
  import uirq_pkg::*;
#(
  parameter int SRC_W  = 3,
  parameter int TID_W  = 4,
  parameter int ADDR_W = 16,
  parameter int ARG_W  = 16,
  parameter int PAY_W  = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_keep,
  input  logic [SRC_W-1:0]  reg_src,
  input  logic [TID_W-1:0]  reg_tid,
  input  logic [ADDR_W-1:0] reg_handler,
  input  logic [ARG_W-1:0]  reg_arg,
  input  logic              pkt_valid,
  input  logic [SRC_W-1:0]  pkt_src,
  input  logic [1:0]        pkt_kind,
  input  logic [PAY_W-1:0]  pkt_payload,
  input  logic [TID_W-1:0]  cur_tid,
  input  logic              hret,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_handler,
  output logic [ARG_W-1:0]  vec_arg,
  output logic [1:0]        vec_kind,
  output logic [SRC_W-1:0]  vec_src,
  output logic [PAY_W-1:0]  vec_payload,
  output logic              os_req,
  output logic [SRC_W-1:0]  os_src,
  output logic [1:0]        os_kind,
  output logic [PAY_W-1:0]  os_payload
);
  localparam int DATA_W = TID_W + ADDR_W + ARG_W + PAY_W + SRC_W;

  logic              tab_hit;
  logic [TID_W-1:0]  tab_tid;
  logic [ADDR_W-1:0] tab_addr;
  logic [ARG_W-1:0]  tab_arg;
  logic              q_full, q_valid, to_user, to_os, issue;
  logic [1:0]        q_kind;
  logic [DATA_W-1:0] q_data;
  logic [TID_W-1:0]  q_tid, vec_tid_q;
  logic [ADDR_W-1:0] q_addr;
  logic [ARG_W-1:0]  q_arg;
  logic [PAY_W-1:0]  q_pay;
  logic [SRC_W-1:0]  q_src;

  uirq_regtab #(.SRC_W(SRC_W), .TID_W(TID_W), .ADDR_W(ADDR_W), .ARG_W(ARG_W)) tab_i (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_keep(reg_keep), .wr_src(reg_src),
    .wr_tid(reg_tid), .wr_addr(reg_handler), .wr_arg(reg_arg), .rd_src(pkt_src),
    .rd_hit(tab_hit), .rd_tid(tab_tid), .rd_addr(tab_addr), .rd_arg(tab_arg));

  // Routing is decided once, on arrival, against the table snapshot.
  assign to_user = pkt_valid && tab_hit && (tab_tid == cur_tid) && !q_full;
  assign to_os   = pkt_valid && !to_user;

  uirq_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) q_i (
    .clk(clk), .rst(rst), .push_i(to_user), .push_kind(pkt_kind),
    .push_data({tab_tid, tab_addr, tab_arg, pkt_payload, pkt_src}),
    .pop_i(issue), .full_o(q_full), .sel_valid(q_valid), .sel_kind(q_kind),
    .sel_data(q_data));

  assign {q_tid, q_addr, q_arg, q_pay, q_src} = q_data;
  assign issue = q_valid && !vec_valid && (q_tid == cur_tid);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      os_req    <= 1'b0;
    end else begin
      os_req <= to_os;
      if (issue)     vec_valid <= 1'b1;
      else if (hret) vec_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (to_os) begin
      os_src     <= pkt_src;
      os_kind    <= pkt_kind;
      os_payload <= pkt_payload;
    end
    if (issue) begin
      vec_handler <= q_addr;
      vec_arg     <= q_arg;
      vec_kind    <= q_kind;
      vec_src     <= q_src;
      vec_payload <= q_pay;
      vec_tid_q   <= q_tid;
    end
  end

  // R5
  one_handler_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !hret) |=> (vec_valid && $stable(vec_handler) && $stable(vec_payload)));

  // R2
  unreg_to_os_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !tab_hit) |=> (os_req && os_src == $past(pkt_src)));

  // R9
  thread_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> (vec_tid_q == $past(cur_tid)));

  // R5
  ret_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && hret) |=> !vec_valid);
endmodule

// File: tb/uirq_dispatch_tb.sv
module uirq_dispatch_tb_top;
  localparam int SRC_W = 3, TID_W = 4, ADDR_W = 16, ARG_W = 16, PAY_W = 16, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, reg_keep = 0;
  logic [SRC_W-1:0] reg_src = '0;
  logic [TID_W-1:0] reg_tid = '0;
  logic [ADDR_W-1:0] reg_handler = '0;
  logic [ARG_W-1:0] reg_arg = '0;
  logic pkt_valid = 0;
  logic [SRC_W-1:0] pkt_src = '0;
  logic [1:0] pkt_kind = '0;
  logic [PAY_W-1:0] pkt_payload = '0;
  logic [TID_W-1:0] cur_tid = '0;
  logic hret = 0;
  logic vec_valid, os_req;
  logic [ADDR_W-1:0] vec_handler;
  logic [ARG_W-1:0] vec_arg;
  logic [1:0] vec_kind, os_kind;
  logic [SRC_W-1:0] vec_src, os_src;
  logic [PAY_W-1:0] vec_payload, os_payload;

  int checks = 0, failures = 0;

  uirq_dispatch #(.SRC_W(SRC_W), .TID_W(TID_W), .ADDR_W(ADDR_W), .ARG_W(ARG_W),
                  .PAY_W(PAY_W), .DEPTH(DEPTH)) dut_i (.*);

  always #10 clk = ~clk;

  // Vector: src[25:23] kind[22:21] payload[20:5] tid[4:1] expect_os[0]
  localparam int NV = 6;
  localparam logic [25:0] VECS [NV] = '{
    {3'd0, 2'd0, 16'h0011, 4'd1, 1'b0},   // R4 registered, thread match
    {3'd1, 2'd1, 16'h0022, 4'd1, 1'b0},   // R4
    {3'd2, 2'd2, 16'h0033, 4'd1, 1'b1},   // R3 owner is thread 2
    {3'd3, 2'd3, 16'h0044, 4'd1, 1'b1},   // R2 unregistered source
    {3'd2, 2'd3, 16'h0055, 4'd2, 1'b0},   // R4 thread 2 owns source 2
    {3'd3, 2'd0, 16'h0066, 4'd2, 1'b1}    // R2
  };

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reg(input logic [SRC_W-1:0] s, input logic [TID_W-1:0] t, input logic keep);
    reg_we = 1; reg_keep = keep; reg_src = s; reg_tid = t;
    reg_handler = 16'h1000 * (16'(s) + 16'd1);
    reg_arg = 16'h00A0 + 16'(s);
    tick;
    reg_we = 0;
  endtask

  task automatic send(input logic [SRC_W-1:0] s, input logic [1:0] k, input logic [PAY_W-1:0] p);
    pkt_valid = 1; pkt_src = s; pkt_kind = k; pkt_payload = p;
    tick;
    pkt_valid = 0;
  endtask

  task automatic ret;
    hret = 1; tick; hret = 0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); tick; tick;
    rst = 0;
    tick;
    check(vec_valid == 0, "R1 vec_valid after reset", 32'(vec_valid), 0);
    check(os_req == 0, "R1 os_req after reset", 32'(os_req), 0);
    cur_tid = 4'd1;
    send(3'd1, 2'd1, 16'h0F0F);
    check(os_req == 1 && os_payload == 16'h0F0F, "R1 empty table routes to OS", 32'(os_payload), 32'h0F0F);
    tick;
    check(vec_valid == 0, "R1 no vector from empty table", 32'(vec_valid), 0);

    do_reg(3'd0, 4'd1, 1);
    do_reg(3'd1, 4'd1, 1);
    do_reg(3'd2, 4'd2, 1);

    for (int v = 0; v < NV; v++) begin
      logic [SRC_W-1:0] s;
      logic [PAY_W-1:0] p;
      s = VECS[v][25:23];
      p = VECS[v][20:5];
      cur_tid = VECS[v][4:1];
      send(s, VECS[v][22:21], p);
      if (VECS[v][0]) begin
        check(os_req == 1, "R2/R3 diverted to OS", 32'(os_req), 1);
        check(os_payload == p && os_src == s && os_kind == VECS[v][22:21], "R2 OS fields", 32'(os_payload), 32'(p));
        tick;
        check(vec_valid == 0 && os_req == 0, "R3 no vector, one-cycle OS pulse", 32'({vec_valid, os_req}), 0);
      end else begin
        check(os_req == 0 && vec_valid == 0, "R4 no OS, vector not yet", 32'({os_req, vec_valid}), 0);
        tick;
        check(vec_valid == 1, "R4 vector raised", 32'(vec_valid), 1);
        check(vec_handler == 16'h1000 * (16'(s) + 16'd1), "R4 handler", 32'(vec_handler), 32'(16'h1000 * (16'(s) + 16'd1)));
        check(vec_arg == 16'h00A0 + 16'(s) && vec_payload == p && vec_src == s, "R4 arg/payload", 32'(vec_payload), 32'(p));
        ret;
        check(vec_valid == 0, "R5 cleared by return", 32'(vec_valid), 0);
      end
    end

    // Burst behind an active handler: ordering and full queue.
    cur_tid = 4'd1;
    send(3'd0, 2'd2, 16'h0100);
    tick;
    check(vec_valid == 1 && vec_payload == 16'h0100, "R4 burst head", 32'(vec_payload), 32'h0100);
    send(3'd0, 2'd2, 16'h000A);
    send(3'd0, 2'd3, 16'h000B);
    send(3'd0, 2'd1, 16'h000C);
    send(3'd0, 2'd0, 16'h000D);
    check(vec_payload == 16'h0100 && vec_valid == 1, "R5 vector held until return", 32'(vec_payload), 32'h0100);
    send(3'd1, 2'd0, 16'h000E);
    check(os_req == 1 && os_payload == 16'h000E, "R8 full queue diverts to OS", 32'(os_payload), 32'h000E);
    ret;
    check(vec_valid == 0, "R5 no vector on return edge", 32'(vec_valid), 0);
    tick;
    check(vec_payload == 16'h000D && vec_kind == 2'd0, "R6 miss first", 32'(vec_payload), 32'h000D);
    ret; tick;
    check(vec_payload == 16'h000C, "R6 task-done second", 32'(vec_payload), 32'h000C);
    ret; tick;
    check(vec_payload == 16'h000A, "R7 older granted before refused", 32'(vec_payload), 32'h000A);
    ret; tick;
    check(vec_payload == 16'h000B, "R7 refused last", 32'(vec_payload), 32'h000B);
    ret; tick;
    check(vec_valid == 0, "R5 queue drained", 32'(vec_valid), 0);

    // Thread switch while a packet waits.
    send(3'd0, 2'd1, 16'h0300);
    tick;
    send(3'd0, 2'd1, 16'h0200);
    cur_tid = 4'd5;
    ret; tick; tick;
    check(vec_valid == 0, "R9 waits for owning thread", 32'(vec_valid), 0);
    cur_tid = 4'd1;
    tick;
    check(vec_valid == 1 && vec_payload == 16'h0200, "R9 issued when owner runs", 32'(vec_payload), 32'h0200);
    ret;

    // Unregister.
    do_reg(3'd0, 4'd1, 0);
    send(3'd0, 2'd0, 16'h0400);
    check(os_req == 1 && os_payload == 16'h0400, "R10 removed entry routes to OS", 32'(os_payload), 32'h0400);
    tick; tick;
    check(vec_valid == 0, "R10 no vector after removal", 32'(vec_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule